// File: doc/BRIEF.md
# Privileged Status and Exception Return Unit

This unit keeps a processor's privileged status word, its three return-address registers (exception, error and debug), the debug-mode flag and the load-link reservation state. It carries out five privileged operations, each selected by one bit of a one-hot strobe: interrupt disable, interrupt enable, exception return, exception return that keeps the load-link reservation, and debug return. Interrupt enable and disable report the status word as it stood before the change. The three return operations send a redirect target to the fetch stage.

Exception return picks its target by priority. A set error level wins, and the return goes through the error-return register. Otherwise the return goes through the exception-return register. Only the level that was used is cleared. The privilege mode is decoded combinationally from the registered status word. It therefore follows every status change in the cycle after the edge that made it.

Status word bit positions used throughout: bit 0 interrupt enable, bit 1 exception level, bit 2 error level, bits 4:3 the mode field (00 kernel, 01 supervisor, 10 user). Operation strobe bits are: 0 disable interrupts, 1 enable interrupts, 2 exception return, 3 exception return keeping the load-link state, 4 debug return. The mode output is coded 0 kernel, 1 supervisor, 2 user, 3 error level.

Top module: `priv_return_unit`

## Requirements
- R1: After reset the status word equals the RST_STATUS parameter (default 0x4, error level set), mode_o is 3, and redir_vld_o, res_vld_o, dm_o and ll_valid_o are 0.
- R2: Strobe bit 0 clears status bit 0 at the next edge. In the following cycle res_vld_o is 1 and res_o holds the status word from before the edge.
- R3: Strobe bit 1 sets status bit 0 at the next edge. In the following cycle res_vld_o is 1 and res_o holds the status word from before the edge.
- R4: Strobe bit 2 or 3 with status bit 2 set redirects to the error-return register and clears bit 2 only, leaving bit 1 as it was.
- R5: Strobe bit 2 or 3 with status bit 2 clear redirects to the exception-return register and clears bit 1.
- R6: Strobe bit 2 forces ll_addr_o to 1 and ll_valid_o to 0, overriding a same-cycle ll_set_i. Strobe bit 3 leaves both unchanged unless ll_set_i loads them.
- R7: Strobe bit 4 clears dm_o and redirects to the debug-return register, and the status word does not change.
- R8: mode_o is 3 when status bit 2 is set, else 0 when bit 1 is set, else the value of bits 4:3. A status write carrying 11 in bits 4:3 keeps the old mode field and updates the other bits.
- R9: redir_vld_o is 1 for exactly the one cycle after each return strobe and stays 0 after interrupt enable or disable and after idle cycles.
- R10: A return in the same cycle as a write to its return register redirects to the value from before the write. The written value is stored and is used by the next return.
- R11: A status write in a cycle with any strobe bit set is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | One-hot operation strobe |
| status_we_i | input | 1 | Status word write enable |
| status_wdata_i | input | SW | Status write data |
| epc_we_i | input | 1 | Exception-return register write enable |
| epc_wdata_i | input | XLEN | Exception-return write data |
| errpc_we_i | input | 1 | Error-return register write enable |
| errpc_wdata_i | input | XLEN | Error-return write data |
| depc_we_i | input | 1 | Debug-return register write enable |
| depc_wdata_i | input | XLEN | Debug-return write data |
| dbg_enter_i | input | 1 | Sets the debug-mode flag |
| ll_set_i | input | 1 | Opens a load-link reservation |
| ll_addr_i | input | XLEN | Reservation address |
| status_o | output | SW | Status word |
| res_vld_o | output | 1 | Result pulse after interrupt enable or disable |
| res_o | output | SW | Status value from before the enable or disable |
| redir_vld_o | output | 1 | Redirect pulse |
| redir_pc_o | output | XLEN | Redirect target |
| dm_o | output | 1 | Debug-mode flag |
| ll_valid_o | output | 1 | Load-link reservation valid |
| ll_addr_o | output | XLEN | Load-link address |
| mode_o | output | 2 | Derived privilege mode |

## Verification
Two things can land in the same cycle here. A return can coincide with a software write to the register it reads, and a status write or reservation set can coincide with an operation. The bench forces these collisions in directed steps and then in a long random run where the write enables fire independently of the strobe. A behavioural reference model, updated on the same edge, decides each outcome: the return must use the old register value, and the status write must be dropped.

// File: rtl/priv_return_unit.sv
module priv_return_unit #(
  parameter int XLEN = 32,
  parameter int SW = 32,
  parameter logic [SW-1:0] RST_STATUS = 'h4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      op_i,
  input  logic            status_we_i,
  input  logic [SW-1:0]   status_wdata_i,
  input  logic            epc_we_i,
  input  logic [XLEN-1:0] epc_wdata_i,
  input  logic            errpc_we_i,
  input  logic [XLEN-1:0] errpc_wdata_i,
  input  logic            depc_we_i,
  input  logic [XLEN-1:0] depc_wdata_i,
  input  logic            dbg_enter_i,
  input  logic            ll_set_i,
  input  logic [XLEN-1:0] ll_addr_i,
  output logic [SW-1:0]   status_o,
  output logic            res_vld_o,
  output logic [SW-1:0]   res_o,
  output logic            redir_vld_o,
  output logic [XLEN-1:0] redir_pc_o,
  output logic            dm_o,
  output logic            ll_valid_o,
  output logic [XLEN-1:0] ll_addr_o,
  output logic [1:0]      mode_o
);
  localparam int IE = 0;
  localparam int EXL = 1;
  localparam int ERL = 2;
  localparam int KSU = 3;

  logic [SW-1:0]   status_q, status_d;
  logic [XLEN-1:0] epc_q, errpc_q, depc_q, ret_pc;

  wire do_di    = op_i[0];
  wire do_ei    = op_i[1];
  wire do_eret  = op_i[2];
  wire do_eretk = op_i[3];
  wire do_dret  = op_i[4];
  wire ret_exc  = do_eret | do_eretk;
  wire any_op   = |op_i;

  always_comb begin
    status_d = status_q;
    if (!any_op && status_we_i) begin
      status_d = status_wdata_i;
      if (status_wdata_i[KSU+:2] == 2'b11) status_d[KSU+:2] = status_q[KSU+:2];
    end
    if (do_di) status_d[IE] = 1'b0;
    if (do_ei) status_d[IE] = 1'b1;
    if (ret_exc) begin
      if (status_q[ERL]) status_d[ERL] = 1'b0;
      else               status_d[EXL] = 1'b0;
    end
  end

  assign ret_pc = do_dret ? depc_q : (status_q[ERL] ? errpc_q : epc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q    <= RST_STATUS;
      epc_q       <= '0;
      errpc_q     <= '0;
      depc_q      <= '0;
      res_vld_o   <= 1'b0;
      res_o       <= '0;
      redir_vld_o <= 1'b0;
      redir_pc_o  <= '0;
      dm_o        <= 1'b0;
      ll_valid_o  <= 1'b0;
      ll_addr_o   <= '0;
    end else begin
      status_q    <= status_d;
      res_vld_o   <= do_di | do_ei;
      if (do_di | do_ei) res_o <= status_q;
      redir_vld_o <= ret_exc | do_dret;
      if (ret_exc | do_dret) redir_pc_o <= ret_pc;
      if (epc_we_i)   epc_q   <= epc_wdata_i;
      if (errpc_we_i) errpc_q <= errpc_wdata_i;
      if (depc_we_i)  depc_q  <= depc_wdata_i;
      if (do_dret)          dm_o <= 1'b0;
      else if (dbg_enter_i) dm_o <= 1'b1;
      if (do_eret) begin
        ll_valid_o <= 1'b0;
        ll_addr_o  <= XLEN'(1);
      end else if (ll_set_i) begin
        ll_valid_o <= 1'b1;
        ll_addr_o  <= ll_addr_i;
      end
    end
  end

  assign status_o = status_q;
  assign mode_o = status_q[ERL] ? 2'd3 : (status_q[EXL] ? 2'd0 : status_q[KSU+:2]);

  AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(op_i)); // R9
  AST_REDIR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |-> $past(op_i[2] | op_i[3] | op_i[4])); // R9
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    do_di |=> (!status_o[IE] && res_vld_o)); // R2
  AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    do_ei |=> (status_o[IE] && res_vld_o)); // R3
  AST_ERL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_exc && status_q[ERL]) |=> (!status_o[ERL] && $stable(status_o[EXL]) && redir_pc_o == $past(errpc_q))); // R4
  AST_EXL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_exc && !status_q[ERL]) |=> (!status_o[EXL] && redir_pc_o == $past(epc_q))); // R5
  AST_ERET_LL_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    do_eret |=> (!ll_valid_o && ll_addr_o == XLEN'(1))); // R6
  AST_ERETK_LL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_eretk && !ll_set_i) |=> ($stable(ll_valid_o) && $stable(ll_addr_o))); // R6
  AST_DRET: assert property (@(posedge clk) disable iff (!rst_n)
    do_dret |=> (!dm_o && $stable(status_o))); // R7
  AST_KSU_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[KSU+:2] != 2'b11); // R8
  AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[3] || op_i[4]) |=> $stable(status_o[SW-1:KSU])); // R11
endmodule

// File: tb/test_priv_return_unit.sv
`timescale 1ns/1ps
module test_priv_return_unit;
  logic clk = 0, rst_n = 0;
  logic [4:0] op = 0;
  logic swe = 0, ewe = 0, rwe = 0, dwe = 0, dbg = 0, lls = 0;
  logic [31:0] swd = 0, ewd = 0, rwd = 0, dwd = 0, lla = 0;
  logic [31:0] status, res, rpc, llao;
  logic resv, rv, dm, llv;
  logic [1:0] mode;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  priv_return_unit i_priv_return_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op),
    .status_we_i(swe), .status_wdata_i(swd),
    .epc_we_i(ewe), .epc_wdata_i(ewd),
    .errpc_we_i(rwe), .errpc_wdata_i(rwd),
    .depc_we_i(dwe), .depc_wdata_i(dwd),
    .dbg_enter_i(dbg), .ll_set_i(lls), .ll_addr_i(lla),
    .status_o(status), .res_vld_o(resv), .res_o(res),
    .redir_vld_o(rv), .redir_pc_o(rpc), .dm_o(dm),
    .ll_valid_o(llv), .ll_addr_o(llao), .mode_o(mode));

  // behavioural reference model
  logic [31:0] m_st, m_epc, m_err, m_dep, m_res, m_rpc, m_lla;
  logic m_resv, m_rv, m_dm, m_llv;

  function automatic logic [1:0] m_mode(input logic [31:0] s);
    if (s[2]) return 2'd3;
    if (s[1]) return 2'd0;
    return s[4:3];
  endfunction

  always @(posedge clk) begin
    logic [31:0] ns;
    if (!rst_n) begin
      m_st = 32'h4; m_epc = 0; m_err = 0; m_dep = 0; m_res = 0; m_rpc = 0;
      m_lla = 0; m_resv = 0; m_rv = 0; m_dm = 0; m_llv = 0;
    end else begin
      ns = m_st;
      if (op == 0 && swe) begin
        ns = swd;
        if (swd[4:3] == 2'b11) ns[4:3] = m_st[4:3];
      end
      m_resv = 0; m_rv = 0;
      case (op)
        5'b00001: begin m_res = m_st; m_resv = 1; ns[0] = 0; end
        5'b00010: begin m_res = m_st; m_resv = 1; ns[0] = 1; end
        5'b00100, 5'b01000: begin
          m_rv = 1;
          if (m_st[2]) begin m_rpc = m_err; ns[2] = 0; end
          else begin m_rpc = m_epc; ns[1] = 0; end
        end
        5'b10000: begin m_rv = 1; m_rpc = m_dep; end
        default: ;
      endcase
      if (op == 5'b10000) m_dm = 0; else if (dbg) m_dm = 1;
      if (op == 5'b00100) begin m_llv = 0; m_lla = 1; end
      else if (lls) begin m_llv = 1; m_lla = lla; end
      if (ewe) m_epc = ewd;
      if (rwe) m_err = rwd;
      if (dwe) m_dep = dwd;
      m_st = ns;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(status == m_st, "R11 status", status, m_st);
    chk(resv == m_resv, "R2 res_vld", 32'(resv), 32'(m_resv));
    chk(res == m_res, "R3 res", res, m_res);
    chk(rv == m_rv, "R9 redir_vld", 32'(rv), 32'(m_rv));
    chk(rpc == m_rpc, "R10 redir_pc", rpc, m_rpc);
    chk(dm == m_dm, "R7 dm", 32'(dm), 32'(m_dm));
    chk(llv == m_llv, "R6 ll_valid", 32'(llv), 32'(m_llv));
    chk(llao == m_lla, "R6 ll_addr", llao, m_lla);
    chk(mode == m_mode(m_st), "R8 mode", 32'(mode), 32'(m_mode(m_st)));
  end

  task automatic idle();
    op = 0; swe = 0; ewe = 0; rwe = 0; dwe = 0; dbg = 0; lls = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1 reset state
    chk(status == 32'h4, "R1 status", status, 32'h4);
    chk(mode == 2'd3, "R1 mode", 32'(mode), 3);
    chk({rv, resv, dm, llv} == 4'b0, "R1 flags", 32'({rv, resv, dm, llv}), 0);

    swe = 1; swd = 32'h7; ewe = 1; ewd = 32'h100; rwe = 1; rwd = 32'h200;
    dwe = 1; dwd = 32'h300; lls = 1; lla = 32'h40; dbg = 1;
    step(); idle();
    op = 5'b00001; step(); idle();
    chk(status[0] == 0, "R2 ie cleared", status, 32'h6);
    chk(resv && res == 32'h7, "R2 prior value", res, 32'h7);
    op = 5'b00010; step(); idle();
    chk(status[0] == 1 && res == 32'h6, "R3 ie set/prior", res, 32'h6);
    chk(rv == 0, "R9 no redirect on enable", 32'(rv), 0);
    op = 5'b00100; step(); idle();
    chk(rv && rpc == 32'h200, "R4 error return target", rpc, 32'h200);
    chk(status == 32'h3, "R4 only error level cleared", status, 32'h3);
    chk(llv == 0 && llao == 1, "R6 reservation broken", llao, 1);
    chk(mode == 2'd0, "R8 kernel via exception level", 32'(mode), 0);
    lls = 1; lla = 32'h80; step(); idle();
    chk(rv == 0, "R9 single pulse", 32'(rv), 0);
    op = 5'b01000; step(); idle();
    chk(rv && rpc == 32'h100, "R5 exception return target", rpc, 32'h100);
    chk(status == 32'h1, "R5 exception level cleared", status, 32'h1);
    chk(llv && llao == 32'h80, "R6 reservation kept", llao, 32'h80);
    swe = 1; swd = 32'h11; step(); idle();
    chk(mode == 2'd2, "R8 user mode", 32'(mode), 2);
    swe = 1; swd = 32'h19; step(); idle();
    chk(status == 32'h11, "R8 illegal field kept", status, 32'h11);
    op = 5'b00100; ewe = 1; ewd = 32'h500; step(); idle();
    chk(rpc == 32'h100, "R10 old register value", rpc, 32'h100);
    op = 5'b01000; step(); idle();
    chk(rpc == 32'h500, "R10 new value stored", rpc, 32'h500);
    op = 5'b00001; swe = 1; swd = 32'h0; step(); idle();
    chk(status == 32'h10, "R11 write dropped", status, 32'h10);
    op = 5'b10000; step(); idle();
    chk(rv && rpc == 32'h300, "R7 debug return target", rpc, 32'h300);
    chk(dm == 0 && status == 32'h10, "R7 flag cleared", 32'(dm), 0);

    for (int n = 0; n < 3000; n++) begin
      int k;
      k = $urandom % 8;
      op = (k < 5) ? 5'(1 << k) : 5'b0;
      swe = $urandom % 2; swd = $urandom % 32;
      ewe = $urandom % 3 == 0; ewd = $urandom;
      rwe = $urandom % 3 == 0; rwd = $urandom;
      dwe = $urandom % 3 == 0; dwd = $urandom;
      dbg = $urandom % 4 == 0; lls = $urandom % 3 == 0; lla = $urandom;
      step();
    end
    idle(); step();
    finish_run();
  end
endmodule